// File: doc/BRIEF.md
# Infrared Remote Carrier Synthesizer

This block derives an infrared remote-control carrier from the system oscillator clock. A 2-bit mode code picks one of four shapes: no carrier, a half-duty wave at one eighth of the clock, a half-duty wave at one twelfth of the clock, or a one-twelfth wave that is high for only a third of its period. With a 455 kHz clock the two rates are about 56.9 kHz and 37.9 kHz. The single output line drives a push-pull output pin.

Firmware controls the carrier with two inputs. The mode code sits in the two top bits of a status byte that firmware writes, and it reaches this block as a plain 2-bit input. A gate input turns carrier bursts on and off. The block changes shape only on a period boundary, so a mode change never leaves a runt pulse on the line. Dropping the gate clears the divider, so each new burst starts with a full high phase.

Top module: `ir_carrier_synth`

## Requirements
- R1: While `rst` is high at a clock edge, the output is low and the divider and the active mode are cleared. After reset the active mode is "no carrier" (code 2'b00).
- R2: Mode code 2'b00 holds `carrier_out` low for as long as it is the active mode.
- R3: Mode code 2'b01 gives a period of 8 clocks, with 4 high followed by 4 low.
- R4: Mode code 2'b10 gives a period of 12 clocks, with 6 high followed by 6 low.
- R5: Mode code 2'b11 gives a period of 12 clocks, with 4 high followed by 8 low.
- R6: While a carrier runs, a new value on `mode_sel` is taken up only on the edge where the divider wraps to zero. The period already under way finishes in the old shape. This also applies to a change to 2'b00.
- R7: Every period begins with its high phase, starting on the edge at which the divider wraps to zero. From idle, the first high phase begins on the first edge that samples `gate_en` high together with a nonzero `mode_sel`.
- R8: An edge that samples `gate_en` low drives the output low and clears the divider and the active mode. When the gate is raised again, the burst starts with a full-length high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| gate_en | input | 1 | Burst gate from firmware; low forces the output idle |
| mode_sel | input | 2 | Requested carrier shape code |
| carrier_out | output | 1 | Registered carrier waveform |

## Verification
Any corruption of the divider count or of the latched mode shows up at the output no later than one period (12 clocks). It appears as a high or low phase of the wrong length, a rising edge away from the period start, or a shape change in the middle of a period. A gate or reset that fails to clear the state shows up on the first edge after the gate rises again, as a short first high phase. The bench compares the line every cycle against a requirement-level model, during directed bursts and during random mode, gate and reset traffic.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

    localparam int SHAPE_W = 8;

    typedef enum logic [1:0] {
        CARR_OFF       = 2'b00,
        CARR_D8_HALF   = 2'b01,
        CARR_D12_HALF  = 2'b10,
        CARR_D12_THIRD = 2'b11
    } carr_mode_e;

    typedef struct packed {
        logic [SHAPE_W-1:0] period;
        logic [SHAPE_W-1:0] high;
    } shape_t;

    // Period and high-phase length for a mode, given the two divisors.
    function automatic shape_t shape_of(carr_mode_e m, int fast_div, int slow_div);
        shape_t s;
        case (m)
            CARR_D8_HALF: begin
                s.period = SHAPE_W'(fast_div);
                s.high   = SHAPE_W'(fast_div / 2);
            end
            CARR_D12_HALF: begin
                s.period = SHAPE_W'(slow_div);
                s.high   = SHAPE_W'(slow_div / 2);
            end
            CARR_D12_THIRD: begin
                s.period = SHAPE_W'(slow_div);
                s.high   = SHAPE_W'(slow_div / 3);
            end
            default: begin
                s.period = '0;
                s.high   = '0;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/carrier_mode_latch.sv
module carrier_mode_latch
    import ir_carrier_pkg::*;
#(
    parameter int FAST_DIV = 8,
    parameter int SLOW_DIV = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       gate_en,
    input  logic [1:0] mode_req,
    input  logic       wrap,
    output carr_mode_e act_mode,
    output shape_t     act_shape,
    output logic       restart
);

    carr_mode_e act_q;

    // A period boundary: idle, or the divider is at its last count.
    assign restart   = gate_en && ((act_q == CARR_OFF) || wrap);
    assign act_mode  = act_q;
    assign act_shape = shape_of(act_q, FAST_DIV, SLOW_DIV);

    always_ff @(posedge clk) begin
        if (rst || !gate_en) begin
            act_q <= CARR_OFF;
        end else if (restart) begin
            act_q <= carr_mode_e'(mode_req);
        end
    end

    // Mode is held for the whole of a running period.
    assert_mode_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (gate_en && act_q != CARR_OFF && !wrap) |=> $stable(act_q));

endmodule

// File: rtl/carrier_div_counter.sv
module carrier_div_counter
    import ir_carrier_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_en,
    input  logic             restart,
    input  logic [SHAPE_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    logic [CNT_W-1:0] cnt_q;

    assign cnt  = cnt_q;
    assign wrap = (period != '0) && (SHAPE_W'(cnt_q) == period - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !gate_en || restart) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_gate_clears_R8: assert property (@(posedge clk) disable iff (rst)
        !gate_en |=> (cnt_q == '0));

    // The count never leaves the active period (R3, R4, R5).
    assert_cnt_in_period_R4: assert property (@(posedge clk) disable iff (rst)
        (period != '0) |-> (SHAPE_W'(cnt_q) < period));

endmodule

// File: rtl/carrier_duty_shaper.sv
module carrier_duty_shaper
    import ir_carrier_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_en,
    input  logic             restart,
    input  logic [1:0]       mode_req,
    input  carr_mode_e       act_mode,
    input  shape_t           act_shape,
    input  logic [CNT_W-1:0] cnt,
    output logic             wave
);

    logic out_q;
    logic [SHAPE_W-1:0] cnt_next;

    assign cnt_next = SHAPE_W'(cnt) + 1'b1;
    assign wave     = out_q;

    always_ff @(posedge clk) begin
        if (rst || !gate_en) begin
            out_q <= 1'b0;
        end else if (restart) begin
            out_q <= (mode_req != 2'b00);
        end else begin
            out_q <= (cnt_next < act_shape.high);
        end
    end

    assert_off_low_R2: assert property (@(posedge clk) disable iff (rst)
        (act_mode == CARR_OFF) |-> !out_q);

    assert_rise_at_zero_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(out_q) |-> (cnt == '0));

    // High only inside the active high window (R3, R4, R5).
    assert_high_window_R5: assert property (@(posedge clk) disable iff (rst)
        out_q |-> (SHAPE_W'(cnt) < act_shape.high));

endmodule

// File: rtl/ir_carrier_synth.sv
module ir_carrier_synth
    import ir_carrier_pkg::*;
#(
    parameter int FAST_DIV = 8,
    parameter int SLOW_DIV = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       gate_en,
    input  logic [1:0] mode_sel,
    output logic       carrier_out
);

    localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
    localparam int CNT_W   = $clog2(MAX_DIV);

    carr_mode_e       act_mode;
    shape_t           act_shape;
    logic             restart;
    logic             wrap;
    logic [CNT_W-1:0] cnt;

    carrier_mode_latch #(
        .FAST_DIV(FAST_DIV),
        .SLOW_DIV(SLOW_DIV)
    ) u_mode (
        .clk      (clk),
        .rst      (rst),
        .gate_en  (gate_en),
        .mode_req (mode_sel),
        .wrap     (wrap),
        .act_mode (act_mode),
        .act_shape(act_shape),
        .restart  (restart)
    );

    carrier_div_counter #(
        .CNT_W(CNT_W)
    ) u_div (
        .clk    (clk),
        .rst    (rst),
        .gate_en(gate_en),
        .restart(restart),
        .period (act_shape.period),
        .cnt    (cnt),
        .wrap   (wrap)
    );

    carrier_duty_shaper #(
        .CNT_W(CNT_W)
    ) u_shape (
        .clk      (clk),
        .rst      (rst),
        .gate_en  (gate_en),
        .restart  (restart),
        .mode_req (mode_sel),
        .act_mode (act_mode),
        .act_shape(act_shape),
        .cnt      (cnt),
        .wave     (carrier_out)
    );

endmodule

// File: tb/test_ir_carrier_synth.sv
module test_ir_carrier_synth;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       gate_en = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       carrier_out;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit model_on = 1'b0;

    // Requirement-level model state
    int m_act = 0;
    int m_cnt = 0;
    bit m_out = 1'b0;

    always #2 clk = ~clk;

    ir_carrier_synth i_ir_carrier_synth (
        .clk        (clk),
        .rst        (rst),
        .gate_en    (gate_en),
        .mode_sel   (mode_sel),
        .carrier_out(carrier_out)
    );

    function automatic int per_of(int m);
        case (m)
            1: return 8;
            2: return 12;
            3: return 12;
            default: return 0;
        endcase
    endfunction

    function automatic int high_of(int m);
        case (m)
            1: return 4;
            2: return 6;
            3: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(int m);
        case (m)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R2";
        endcase
    endfunction

    function automatic bit pat(int m, int k);
        return (m != 0) && ((k % per_of(m)) < high_of(m));
    endfunction

    task automatic chk(string req, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: got %b expected %b", req, cyc, got, exp);
        end
    endtask

    // Model from R1-R8: boundary on idle or last count; gate/reset clear.
    always @(posedge clk) begin
        cyc++;
        if (rst || !gate_en) begin
            m_act = 0; m_cnt = 0; m_out = 1'b0;
        end else if (m_act == 0 || m_cnt == per_of(m_act) - 1) begin
            m_act = int'(mode_sel); m_cnt = 0; m_out = (mode_sel != 2'b00);
        end else begin
            m_cnt++;
            m_out = (m_cnt < high_of(m_act));
        end
    end

    always @(negedge clk) begin
        if (model_on && !done) chk({req_of(m_act), "/R6/R8 model"}, carrier_out, m_out);
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog R1..: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic go_idle();
        gate_en = 1'b0;
        @(negedge clk);
    endtask

    // Directed burst from idle with the per-mode pattern.
    task automatic burst(int m, int n);
        go_idle();
        mode_sel = 2'(m);
        gate_en  = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk({req_of(m), "/R7 burst"}, carrier_out, pat(m, k));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset", carrier_out, 1'b0);
        gate_en = 1'b1; mode_sel = 2'b01;
        @(negedge clk);
        chk("R1 reset held", carrier_out, 1'b0);
        rst = 1'b0; gate_en = 1'b0; mode_sel = 2'b00;
        @(negedge clk);
        model_on = 1'b1;

        // R2: gate high, mode off
        gate_en = 1'b1; mode_sel = 2'b00;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk("R2 off", carrier_out, 1'b0);
        end

        burst(1, 24);
        burst(2, 36);
        burst(3, 36);

        // R6: 01 -> 10 at count 2, then 10 -> 00 at count 3
        go_idle();
        mode_sel = 2'b01; gate_en = 1'b1;
        for (int k = 0; k < 40; k++) begin
            bit e;
            @(negedge clk);
            if (k < 8)       e = pat(1, k);
            else if (k < 20) e = pat(2, k - 8);
            else             e = 1'b0;
            chk("R6 switch at boundary", carrier_out, e);
            if (k == 2)  mode_sel = 2'b10;
            if (k == 11) mode_sel = 2'b00;
        end

        // R8: gate drop mid high phase, then full restart
        go_idle();
        mode_sel = 2'b11; gate_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R5 pre-gate", carrier_out, pat(3, k));
        end
        gate_en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 gate low", carrier_out, 1'b0);
        end
        gate_en = 1'b1;
        for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            chk("R8 full restart", carrier_out, pat(3, k));
        end

        // Random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(19, 0) == 0) mode_sel = 2'($urandom_range(3, 0));
            if ($urandom_range(39, 0) == 0) gate_en = ~gate_en;
            rst = ($urandom_range(499, 0) == 0);
            @(negedge clk);
        end
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule